// File: doc/BRIEF.md
# Half-Duplex Sensor Register Interface Master

This block drives a three-wire serial link to an optical motion sensor: a clock output that idles high, one shared data line split into an output, an output enable and an input, and an active-low select. A host presents commands on a valid/ready handshake. The four commands are register read, register write, two-byte motion burst and line resynchronisation. Each command ends with a one-cycle done pulse, and any returned data is presented at the same time.

Every bit period and gap comes from a system-clock count. Each count is a microsecond figure multiplied by the `CLK_PER_US` parameter. The data line changes direction partway through a read, so a programmable turnaround gap follows every address byte. The master releases the line at the start of that gap. A burst is ended early: the select is released as soon as the two motion bytes have been clocked in.

Top module: `sensor_link_master`

## Requirements
- R1: After reset, and whenever no command is in progress, `cs_n` is 1, `sclk` is 1, `sdio_oe` is 0 and `cmd_ready` is 1.
- R2: Every byte is shifted most significant bit first, 8 bits per byte. For a driven bit, `sclk` falls with the bit on `sdio_out` and `sdio_oe` high, and stays low for TX_HOLD_US*CLK_PER_US cycles before it rises.
- R3: A write (`cmd_op` = 2'b01) lowers `cs_n`, sends `{1'b1, cmd_addr}`, then sends `cmd_wdata`, then raises `cs_n` and pulses `rsp_done`.
- R4: A read (`cmd_op` = 2'b00) sends `{1'b0, cmd_addr}` and then clocks in 8 bits. For each bit, `sclk` is low for RX_SETUP_US*CLK_PER_US cycles, `sdio_in` is sampled in the last of those cycles, and `sclk` is then high for RX_HIGH_US*CLK_PER_US cycles. `cs_n` stays low for a further TAIL_US*CLK_PER_US cycles. The byte appears on `rsp_rdata` with `rsp_done`.
- R5: After the last address bit rises, `sclk` stays high for 1 + TURN_US*CLK_PER_US cycles before the next bit. `sdio_oe` is 0 throughout every read bit.
- R6: A burst (`cmd_op` = 2'b10) sends address byte 8'h63 and clocks in exactly 16 bits. The first byte goes to `rsp_dx` and the second to `rsp_dy`, both as signed two's complement. `cs_n` rises right after the last bit's high time, with no further clocks.
- R7: A resync (`cmd_op` = 2'b11) holds `cs_n` low for RESYNC_US*CLK_PER_US cycles with no `sclk` edges, then pulses `rsp_done`.
- R8: A command is accepted only when `cmd_ready` is 1, and `cmd_ready` is 0 while `cs_n` is low. A `cmd_valid` raised during a transaction starts nothing. `rsp_done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Master idle and able to accept a command |
| cmd_op | input | 2 | 00 read, 01 write, 10 burst, 11 resync |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write data byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte from the last register read |
| rsp_dx | output | 8 | Signed first burst byte |
| rsp_dy | output | 8 | Signed second burst byte |
| sclk | output | 1 | Serial clock, idles high |
| sdio_out | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_in | input | 1 | Data line input value |
| cs_n | output | 1 | Active-low select |

## Verification
The hardest situation to reach from the ports is the direction change. Showing that the master lets go of the line for the whole turnaround, and never drives it while the sensor does, needs a sensor that answers on the wire. The bench therefore models the sensor at the pin level. The model captures address bits on rising clocks and drives read bits on falling clocks. It measures every low pulse and every high gap in system cycles, so turnaround, tail and early burst end are checked as cycle counts. The idle-only rule is reached by holding `cmd_valid` high partway through a write and confirming that no new select occurs.

// File: rtl/sensor_link_pkg.sv
package sensor_link_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] BURST_ADDR = 8'h63;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_BURST  = 2'b10,
        OP_RESYNC = 2'b11
    } link_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_TX_LO, ST_TX_HI, ST_TURN, ST_RX_LO,
        ST_RX_HI, ST_TAIL, ST_RSYNC, ST_FIN
    } link_state_e;

    typedef enum logic [1:0] {
        SEG_ADDR, SEG_FIRST, SEG_SECOND
    } link_seg_e;

    typedef struct packed {
        link_op_e          op;
        logic [BYTE_W-1:0] wdata;
    } link_cmd_t;

    function automatic logic [BYTE_W-1:0] addr_byte(link_op_e op, logic [BYTE_W-2:0] a);
        case (op)
            OP_WRITE: return {1'b1, a};
            OP_BURST: return BURST_ADDR;
            default:  return {1'b0, a};
        endcase
    endfunction

    function automatic int cycles_of(int us, int per_us);
        return (us * per_us < 1) ? 1 : us * per_us;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sensor_link_timer.sv
module sensor_link_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sensor_link_shifter.sv
module sensor_link_shifter
    import sensor_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    input  logic              in_bit,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[BYTE_W-2:0], in_bit};
    end

    // R2
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (q[BYTE_W-1:1] == $past(q[BYTE_W-2:0])));
endmodule

// File: rtl/sensor_link_master.sv
module sensor_link_master
    import sensor_link_pkg::*;
#(
    parameter int CLK_PER_US   = 16,
    parameter int TX_HOLD_US   = 2,
    parameter int RX_SETUP_US  = 1,
    parameter int RX_HIGH_US   = 1,
    parameter int TURN_US      = 4,
    parameter int TAIL_US      = 1,
    parameter int RESYNC_US    = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [6:0]  cmd_addr,
    input  logic [7:0]  cmd_wdata,
    output logic        rsp_done,
    output logic [7:0]  rsp_rdata,
    output logic [7:0]  rsp_dx,
    output logic [7:0]  rsp_dy,
    output logic        sclk,
    output logic        sdio_out,
    output logic        sdio_oe,
    input  logic        sdio_in,
    output logic        cs_n
);
    localparam int C_TX   = cycles_of(TX_HOLD_US, CLK_PER_US);
    localparam int C_RXS  = cycles_of(RX_SETUP_US, CLK_PER_US);
    localparam int C_RXH  = cycles_of(RX_HIGH_US, CLK_PER_US);
    localparam int C_TURN = cycles_of(TURN_US, CLK_PER_US);
    localparam int C_TAIL = cycles_of(TAIL_US, CLK_PER_US);
    localparam int C_RS   = cycles_of(RESYNC_US, CLK_PER_US);
    localparam int C_MAX  = max_of(max_of(max_of(C_TX, C_RXS), max_of(C_RXH, C_TURN)),
                                   max_of(C_TAIL, C_RS));
    localparam int CW     = $clog2(C_MAX + 1);
    localparam int BW     = $clog2(BYTE_W);
    localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);
    localparam logic [CW-1:0] TV_TX   = CW'(C_TX - 1);
    localparam logic [CW-1:0] TV_RXS  = CW'(C_RXS - 1);
    localparam logic [CW-1:0] TV_RXH  = CW'(C_RXH - 1);
    localparam logic [CW-1:0] TV_TURN = CW'(C_TURN - 1);
    localparam logic [CW-1:0] TV_TAIL = CW'(C_TAIL - 1);
    localparam logic [CW-1:0] TV_RS   = CW'(C_RS - 1);

    link_state_e       state, nxt;
    link_seg_e         seg;
    link_cmd_t         cmd_q;
    link_op_e          op_in;
    logic [BW-1:0]     bitn;
    logic              tmr_load, tmr_zero;
    logic [CW-1:0]     tmr_val;
    logic              sh_load, sh_shift, sh_in;
    logic [BYTE_W-1:0] sh_val, sh_q;
    logic [BYTE_W-1:0] rd_q, dx_q, dy_q;

    assign op_in = link_op_e'(cmd_op);

    sensor_link_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sensor_link_shifter u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_val),
        .shift(sh_shift), .in_bit(sh_in), .q(sh_q)
    );

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_val   = '0;
        sh_shift = 1'b0;
        sh_in    = 1'b0;
        case (state)
            ST_IDLE: if (cmd_valid) begin
                tmr_load = 1'b1;
                if (op_in == OP_RESYNC) begin
                    nxt     = ST_RSYNC;
                    tmr_val = TV_RS;
                end else begin
                    nxt     = ST_TX_LO;
                    tmr_val = TV_TX;
                    sh_load = 1'b1;
                    sh_val  = addr_byte(op_in, cmd_addr);
                end
            end
            ST_TX_LO: if (tmr_zero) nxt = ST_TX_HI;
            ST_TX_HI: begin
                sh_shift = 1'b1;
                if (bitn != BIT_LAST) begin
                    nxt      = ST_TX_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TV_TX;
                end else if (seg == SEG_ADDR) begin
                    nxt      = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TV_TURN;
                end else begin
                    nxt = ST_FIN;
                end
            end
            ST_TURN: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (cmd_q.op == OP_WRITE) begin
                    nxt     = ST_TX_LO;
                    tmr_val = TV_TX;
                    sh_load = 1'b1;
                    sh_val  = cmd_q.wdata;
                end else begin
                    nxt     = ST_RX_LO;
                    tmr_val = TV_RXS;
                end
            end
            ST_RX_LO: if (tmr_zero) begin
                sh_shift = 1'b1;
                sh_in    = sdio_in;
                nxt      = ST_RX_HI;
                tmr_load = 1'b1;
                tmr_val  = TV_RXH;
            end
            ST_RX_HI: if (tmr_zero) begin
                if (bitn != BIT_LAST || (cmd_q.op == OP_BURST && seg == SEG_FIRST)) begin
                    nxt      = ST_RX_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TV_RXS;
                end else if (cmd_q.op == OP_READ) begin
                    nxt      = ST_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = TV_TAIL;
                end else begin
                    nxt = ST_FIN;
                end
            end
            ST_TAIL, ST_RSYNC: if (tmr_zero) nxt = ST_FIN;
            ST_FIN: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            seg   <= SEG_ADDR;
            bitn  <= '0;
            cmd_q <= '{op: OP_READ, wdata: '0};
            rd_q  <= '0;
            dx_q  <= '0;
            dy_q  <= '0;
        end else begin
            state <= nxt;
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    cmd_q <= '{op: op_in, wdata: cmd_wdata};
                    seg   <= SEG_ADDR;
                    bitn  <= '0;
                end
                ST_TX_HI: bitn <= bitn + 1'b1;
                ST_TURN:  if (tmr_zero) begin
                    seg  <= SEG_FIRST;
                    bitn <= '0;
                end
                ST_RX_HI: if (tmr_zero) begin
                    bitn <= bitn + 1'b1;
                    if (bitn == BIT_LAST) begin
                        if (cmd_q.op == OP_READ) begin
                            rd_q <= sh_q;
                        end else if (seg == SEG_FIRST) begin
                            dx_q <= sh_q;
                            seg  <= SEG_SECOND;
                        end else begin
                            dy_q <= sh_q;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign cs_n      = (state == ST_IDLE) || (state == ST_FIN);
    assign sclk      = !((state == ST_TX_LO) || (state == ST_RX_LO));
    assign sdio_oe   = (state == ST_TX_LO) || (state == ST_TX_HI);
    assign sdio_out  = sh_q[BYTE_W-1];
    assign rsp_done  = (state == ST_FIN);
    assign rsp_rdata = rd_q;
    assign rsp_dx    = dx_q;
    assign rsp_dy    = dy_q;

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (sclk && !sdio_oe));
    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> cs_n);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R5
    turn_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdio_oe) && !cs_n) |-> sclk);
    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && sdio_oe) |=> $stable(sdio_out));
    // R7
    resync_no_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RSYNC) |-> (sclk && !sdio_oe));
endmodule

// File: tb/sensor_link_master_test.sv
module sensor_link_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 2;
    localparam int C_TX = 2 * CPU, C_RXS = 1 * CPU, C_RXH = 1 * CPU;
    localparam int C_TURN = 2 * CPU, C_TAIL = 1 * CPU, C_RS = 1 * CPU;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, sdio_in = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic cmd_ready, rsp_done, sclk, sdio_out, sdio_oe, cs_n;
    logic [7:0] rsp_rdata, rsp_dx, rsp_dy;

    sensor_link_master #(.CLK_PER_US(CPU), .TX_HOLD_US(2), .RX_SETUP_US(1),
        .RX_HIGH_US(1), .TURN_US(2), .TAIL_US(1), .RESYNC_US(1)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_dx(rsp_dx), .rsp_dy(rsp_dy),
        .sclk(sclk), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdio_in(sdio_in), .cs_n(cs_n));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nchk = 0, nerr = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // pin-level sensor model
    logic [7:0] mem [128];
    logic [7:0] bx = '0, by = '0, abyte = '0, wbyte = '0;
    int bitc = 0;
    always @(negedge cs_n) bitc = 0;
    always @(posedge sclk) if (!cs_n) begin
        if (bitc < 8) abyte = {abyte[6:0], sdio_out};
        else if (abyte[7]) begin
            wbyte = {wbyte[6:0], sdio_out};
            if (bitc == 15) mem[abyte[6:0]] = wbyte;
        end
        bitc++;
    end
    always @(negedge sclk) if (!cs_n && bitc >= 8 && !abyte[7]) begin
        automatic int idx = bitc - 8;
        automatic logic [7:0] b = (abyte == 8'h63) ? ((idx < 8) ? bx : by) : mem[abyte[6:0]];
        sdio_in = b[7 - (idx % 8)];
    end

    typedef struct {
        logic [1:0] op; logic [7:0] abyte; logic [7:0] rd;
        logic [7:0] dx; logic [7:0] dy; int bits;
    } exp_t;
    exp_t q[$];
    logic [1:0] cur_op = 2'b00;
    int cs_falls = 0;

    task automatic issue(input logic [1:0] op, input logic [6:0] a, input logic [7:0] wd,
                         input logic [7:0] rd, input logic [7:0] dx, input logic [7:0] dy);
        exp_t e;
        e.op = op; e.rd = rd; e.dx = dx; e.dy = dy;
        e.abyte = (op == 2'b01) ? {1'b1, a} : (op == 2'b10) ? 8'h63 : {1'b0, a};
        e.bits = (op == 2'b11) ? 0 : (op == 2'b10) ? 24 : 16;
        while (!cmd_ready) @(negedge clk);
        q.push_back(e);
        cur_op = op;
        cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) if (!rst && rsp_done) begin
        exp_t e;
        if (q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
        else begin
            e = q.pop_front();
            chk(bitc == e.bits, "R6 clocked bit count", bitc, e.bits);
            if (e.op != 2'b11) chk(abyte == e.abyte, "R3/R4 address byte", abyte, e.abyte);
            if (e.op == 2'b00) chk(rsp_rdata == e.rd, "R4 read data", rsp_rdata, e.rd);
            if (e.op == 2'b10) begin
                chk($signed(rsp_dx) == $signed(e.dx), "R6 burst dx", rsp_dx, e.dx);
                chk($signed(rsp_dy) == $signed(e.dy), "R6 burst dy", rsp_dy, e.dy);
            end
        end
    end

    // timing monitor
    int hicnt = 0, lowcnt = 0, cslow = 0;
    logic lo_oe = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) if (!rst) begin
        if (!cs_n) cslow++;
        if (!cs_n && prev_cs) begin
            cs_falls++;
            chk(!cmd_ready, "R8 ready low while selected", cmd_ready, 0);
        end
        if (!sclk) begin
            if (lowcnt == 0) begin
                if (bitc == 8) chk(hicnt == C_TURN + 1, "R5 turnaround gap", hicnt, C_TURN + 1);
                if (bitc >= 8 && !abyte[7]) chk(!sdio_oe, "R5 line released on read", sdio_oe, 0);
            end
            lowcnt++; lo_oe = sdio_oe; hicnt = 0;
        end else begin
            if (lowcnt > 0)
                chk(lowcnt == (lo_oe ? C_TX : C_RXS), lo_oe ? "R2 tx low width" : "R4 rx low width",
                    lowcnt, lo_oe ? C_TX : C_RXS);
            lowcnt = 0;
            if (!cs_n) hicnt++;
        end
        if (cs_n && !prev_cs) begin
            if (cur_op == 2'b00) chk(hicnt == C_RXH + C_TAIL, "R4 tail hold", hicnt, C_RXH + C_TAIL);
            if (cur_op == 2'b10) chk(hicnt == C_RXH, "R6 early release", hicnt, C_RXH);
            if (cur_op == 2'b11) chk(cslow == C_RS, "R7 resync width", cslow, C_RS);
            cslow = 0; hicnt = 0;
        end
        prev_cs = cs_n;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
        mem[7'h00] = 8'h12; mem[7'h3F] = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && sclk && !sdio_oe && cmd_ready, "R1 idle after reset",
            {cs_n, sclk, sdio_oe, cmd_ready}, 4'b1101);

        issue(2'b00, 7'h00, 8'h00, 8'h12, 0, 0);           // R4
        issue(2'b00, 7'h3F, 8'h00, 8'hA5, 0, 0);           // R4
        issue(2'b01, 7'h19, 8'h9C, 0, 0, 0);               // R3
        chk(mem[7'h19] == 8'h9C, "R3 write landed", mem[7'h19], 8'h9C);
        issue(2'b00, 7'h19, 8'h00, 8'h9C, 0, 0);           // R2 read back
        issue(2'b01, 7'h7F, 8'h01, 0, 0, 0);               // R3
        chk(mem[7'h7F] == 8'h01, "R3 write top address", mem[7'h7F], 8'h01);
        bx = 8'hF6; by = 8'h05;
        issue(2'b10, 7'h00, 8'h00, 0, 8'hF6, 8'h05);       // R6 -10, +5
        bx = 8'h80; by = 8'h7F;
        issue(2'b10, 7'h00, 8'h00, 0, 8'h80, 8'h7F);       // R6 -128, +127
        issue(2'b11, 7'h00, 8'h00, 0, 0, 0);               // R7
        chk(cs_n && sclk && !sdio_oe && cmd_ready, "R1 idle between commands",
            {cs_n, sclk, sdio_oe, cmd_ready}, 4'b1101);

        // R8: valid held during a write starts nothing
        fork
            issue(2'b01, 7'h22, 8'h5A, 0, 0, 0);
            begin
                repeat (4) @(negedge clk);
                cmd_op = 2'b11; cmd_valid = 1'b1;
                repeat (10) @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        begin
            automatic int f0 = cs_falls;
            repeat (20) @(negedge clk);
            chk(cs_falls == f0, "R8 no command accepted while busy", cs_falls, f0);
        end
        chk(mem[7'h22] == 8'h5A, "R8 busy write intact", mem[7'h22], 8'h5A);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule